// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. A one-entry holding buffer sits in front of the shift register. The host writes a byte into the buffer. At the start of a frame the transmitter copies that byte into its shift register, which frees the buffer straight away. The host can then load the next byte while the current frame is still on the line, so frames can leave back to back with no idle time between them.

Two flags report the state. `buf_full` tells the host whether the buffer can take a write. `shift_busy` tells it whether a frame is still being sent. During continuous sending, the pair {buf_full, shift_busy} never changes both bits in the same cycle. After a write to an idle transmitter the pair moves 10 → 11 → 01. A one-cycle `tx_done` pulse marks the end of every frame. The bit rate comes from an external one-cycle `baud_tick`. A synchronous `init` input returns the block to its empty, idle state.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset or `init`, `txd` is 1, `buf_full` is 0, `shift_busy` is 0 and `tx_done` is 0. Whenever `shift_busy` is 0, `txd` is 1.
- R2: A frame is a start bit at 0, then `wr_data[0]` through `wr_data[7]`, then a stop bit at 1. Each bit lasts one `baud_tick` period. Ticks must be at least 2 clocks apart.
- R3: The clock after an accepted write to an idle, empty transmitter, the flags {buf_full, shift_busy} read 10. On the next `baud_tick` the start bit goes onto the line and the flags read 11 for exactly one clock. The flags then read 01, because the byte has been copied into the shift register.
- R4: A write made while `buf_full` is 1 is ignored. The byte already in the buffer is the one that is sent.
- R5: While a frame is being sent and `buf_full` is 0, a write is accepted and the flags move from 01 to 11.
- R6: `tx_done` goes high for exactly one clock at the end of every stop bit, in the clock after the tick that ends the stop bit.
- R7: If a byte is waiting when a stop bit ends, that byte's start bit begins on that same tick, with no idle bit between frames. `shift_busy` stays 1 across the boundary.
- R8: `buf_full` and `shift_busy` never both change in the same cycle, except through `init`. `shift_busy` returns to 0 only after the last stop bit, once the buffer is empty.
- R9: `init` clears both flags, forces `txd` to 1 and discards any buffered byte, even in the middle of a frame. No frame and no `tx_done` follows until a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous initialise of the transmitter |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| baud_tick | input | 1 | One-cycle bit-rate enable |
| txd | output | 1 | Serial output line, idle high |
| buf_full | output | 1 | Holding buffer occupied; writes are ignored |
| shift_busy | output | 1 | A frame is being sent |
| tx_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench follows the flag pair through its 10 → 11 → 01 path after a first write. A design that copied the byte in the same clock as the start would flip both flags at once, and one that never copied it would hold 11. A write aimed at a full buffer must leave the pending byte intact. A design that overwrote it would send the wrong byte, and the scoreboard would catch the mismatch. The bench measures the number of ticks between the stop bit of one frame and the start bit of the next, and expects exactly one. A design that inserted an idle bit would show two. An `init` in the middle of a frame must silence the line with a byte still waiting; any later frame or completion pulse counts as an error.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  typedef enum logic [2:0] {
    TXQ_IDLE  = 3'd0,
    TXQ_LOAD  = 3'd1,
    TXQ_START = 3'd2,
    TXQ_DATA  = 3'd3,
    TXQ_STOP  = 3'd4
  } txq_state_e;

endpackage

// File: rtl/uart_txq_hold.sv
module uart_txq_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              accept
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;

  assign accept = wr_en & ~full_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (init) begin
      full_d = 1'b0;
    end else begin
      if (take) full_d = 1'b0;
      if (accept) begin
        full_d = 1'b1;
        data_d = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/uart_txq_shift.sv
module uart_txq_shift
  import uart_txq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              baud_tick,
  input  logic              pend_full,
  input  logic              pend_new,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              txd,
  output logic              busy,
  output logic              done
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  txq_state_e        st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    take   = 1'b0;
    unique case (st_q)
      TXQ_IDLE: begin
        if (baud_tick && pend_full) st_d = TXQ_LOAD;
      end
      TXQ_LOAD: begin
        take  = 1'b1;
        sh_d  = hold_data;
        cnt_d = '0;
        st_d  = TXQ_START;
      end
      TXQ_START: begin
        if (baud_tick) st_d = TXQ_DATA;
      end
      TXQ_DATA: begin
        if (baud_tick) begin
          if (cnt_q == LAST_BIT) begin
            st_d = TXQ_STOP;
          end else begin
            sh_d  = sh_q >> 1;
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      TXQ_STOP: begin
        if (baud_tick) begin
          done_d = 1'b1;
          st_d   = (pend_full || pend_new) ? TXQ_LOAD : TXQ_IDLE;
        end
      end
      default: st_d = TXQ_IDLE;
    endcase
    if (init) begin
      st_d   = TXQ_IDLE;
      done_d = 1'b0;
      take   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TXQ_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    unique case (st_q)
      TXQ_LOAD, TXQ_START: txd = 1'b0;
      TXQ_DATA:            txd = sh_q[0];
      default:             txd = 1'b1;
    endcase
  end

  assign busy = (st_q != TXQ_IDLE);
  assign done = done_q;

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  output logic              txd,
  output logic              buf_full,
  output logic              shift_busy,
  output logic              tx_done
);

  logic              hold_take;
  logic              hold_accept;
  logic [DATA_W-1:0] hold_q;

  uart_txq_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (init),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (hold_take),
    .full    (buf_full),
    .data    (hold_q),
    .accept  (hold_accept)
  );

  uart_txq_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .baud_tick (baud_tick),
    .pend_full (buf_full),
    .pend_new  (hold_accept),
    .hold_data (hold_q),
    .take      (hold_take),
    .txd       (txd),
    .busy      (shift_busy),
    .done      (tx_done)
  );

endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic              txd,
  input logic              buf_full,
  input logic              shift_busy,
  input logic              tx_done,
  input logic [DATA_W-1:0] hold_q
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_busy |-> txd) else $error("idle line low"); // R1

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done) else $error("done pulse too wide"); // R6

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> ($past(txd) && $past(shift_busy))) else $error("done without stop bit"); // R6

  AST_FLAGS_NO_JOINT_FLIP: assert property (@(posedge clk) disable iff (!rst_n || init)
    !$past(init) |-> !((buf_full != $past(buf_full)) && (shift_busy != $past(shift_busy))))
    else $error("both flags changed together"); // R8

  AST_HELD_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n || init)
    buf_full |=> $stable(hold_q)) else $error("held byte changed"); // R4

  AST_FREE_ON_START_BIT: assert property (@(posedge clk) disable iff (!rst_n || init)
    ($fell(buf_full) && !$past(init)) |-> (shift_busy && !txd)) else $error("buffer freed off start"); // R3

  AST_BUSY_RISE_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n || init)
    $rose(shift_busy) |-> (!txd && buf_full)) else $error("busy rose without byte"); // R3

endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init       (init),
  .txd        (txd),
  .buf_full   (buf_full),
  .shift_busy (shift_busy),
  .tx_done    (tx_done),
  .hold_q     (hold_q)
);

// File: tb/sim_uart_dbuf_tx.sv
`timescale 1ns/1ps
module sim_uart_dbuf_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       baud_tick = 1'b0;
  logic       txd, buf_full, shift_busy, tx_done;

  uart_dbuf_tx u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .wr_en(wr_en), .wr_data(wr_data),
    .baud_tick(baud_tick), .txd(txd), .buf_full(buf_full),
    .shift_busy(shift_busy), .tx_done(tx_done)
  );

  always #4 clk = ~clk;

  logic [1:0] tdiv = '0;
  always @(posedge clk) begin
    tdiv      <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
  end

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  int mstate = 0, nb = 0, tickno = 0, last_stop = 0, last_gap = 0;
  int frames = 0, dones = 0, flips = 0;
  bit done_wait = 0, prev_done = 0, prev_init = 1;
  logic [7:0] rx;
  logic [1:0] prev_flags = 2'b00;

  always @(negedge clk) begin
    if (!rst_n || init) begin
      mstate = 0; done_wait = 0; exp_q.delete();
    end else begin
      if (done_wait) begin
        chk(tx_done === 1'b1, "R6 done pulse after stop", int'(tx_done), 1);
        done_wait = 0;
      end
      if (tx_done) begin
        dones++;
        if (prev_done) chk(1'b0, "R6 done width", 2, 1);
      end
      if (baud_tick) begin
        tickno++;
        case (mstate)
          0: if (txd === 1'b0) begin
               mstate = 1; nb = 0; last_gap = tickno - last_stop;
             end
          1: begin
               rx[nb] = txd; nb++;
               if (nb == 8) mstate = 2;
             end
          default: begin
            chk(txd === 1'b1, "R2 stop bit", int'(txd), 1);
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected frame", int'(rx), 0);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              chk(rx === e, "R2 R4 frame data", int'(rx), int'(e));
            end
            frames++; last_stop = tickno; done_wait = 1; mstate = 0;
          end
        endcase
      end
    end
    if (rst_n && !init && !prev_init &&
        (buf_full != prev_flags[1]) && (shift_busy != prev_flags[0])) flips++;
    prev_flags = {buf_full, shift_busy};
    prev_init  = init || !rst_n;
    prev_done  = tx_done && rst_n;
  end

  task automatic write_byte(input logic [7:0] b, input bit expect_take);
    wr_en = 1'b1; wr_data = b;
    if (expect_take) exp_q.push_back(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    int guard = 0;
    while (buf_full && guard < 200) begin @(negedge clk); guard++; end
    write_byte(b, 1'b1);
  endtask

  task automatic drain();
    int guard = 0;
    while ((shift_busy || buf_full || exp_q.size() != 0) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] pf;
    int f0, d0;
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1 && buf_full === 1'b0 && shift_busy === 1'b0 && tx_done === 1'b0,
        "R1 reset state", {txd, buf_full, shift_busy, tx_done}, 4'b1000);

    // R3: first write into idle, on a tick cycle
    while (!baud_tick) @(negedge clk);
    write_byte(8'h3C, 1'b1);
    chk({buf_full, shift_busy} === 2'b10, "R3 flags after write", {buf_full, shift_busy}, 2'b10);
    pf = {buf_full, shift_busy};
    for (int i = 0; i < 20 && {buf_full, shift_busy} != 2'b11; i++) begin
      pf = {buf_full, shift_busy};
      @(negedge clk);
    end
    chk({buf_full, shift_busy} === 2'b11 && pf === 2'b10, "R3 flags 10 to 11", {pf, buf_full, shift_busy}, 4'b1011);
    chk(txd === 1'b0, "R3 start bit on line", int'(txd), 0);
    @(negedge clk);
    chk({buf_full, shift_busy} === 2'b01, "R3 flags 11 to 01", {buf_full, shift_busy}, 2'b01);

    // R5: second byte during first frame
    write_byte(8'hC3, 1'b1);
    chk({buf_full, shift_busy} === 2'b11, "R5 write accepted mid frame", {buf_full, shift_busy}, 2'b11);

    // R4: write while full is ignored
    write_byte(8'h77, 1'b0);
    chk({buf_full, shift_busy} === 2'b11, "R4 flags after ignored write", {buf_full, shift_busy}, 2'b11);
    drain();
    chk(last_gap == 1, "R7 no idle bit between frames", last_gap, 1);
    chk(frames == 2 && dones == 2, "R6 one done per frame", dones, 2);
    chk(shift_busy === 1'b0 && txd === 1'b1, "R8 busy low after last frame", {shift_busy, txd}, 2'b01);

    // several patterns back to back
    foreach (pats[k]) send(pats[k]);
    drain();
    chk(frames == 8 && dones == 8, "R2 R6 pattern frames", frames, 8);
    chk(last_gap == 1, "R7 continuous stream", last_gap, 1);

    // R9: init mid frame with a byte waiting
    send(8'h96);
    send(8'h69);
    repeat (12) @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk({buf_full, shift_busy, txd} === 3'b001, "R9 init clears", {buf_full, shift_busy, txd}, 3'b001);
    f0 = frames; d0 = dones;
    begin
      bit low_seen = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (txd !== 1'b1 || shift_busy !== 1'b0) low_seen = 1;
      end
      chk(!low_seen && frames == f0 && dones == d0, "R9 byte discarded", int'(low_seen), 0);
      chk(txd === 1'b1 && shift_busy === 1'b0 && buf_full === 1'b0,
          "R1 idle after init", {txd, shift_busy, buf_full}, 3'b100);
    end
    send(8'hE1);
    drain();
    chk(frames == f0 + 1, "R9 sends after init", frames, f0 + 1);

    chk(flips == 0, "R8 no joint flag change", flips, 0);
    chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule